// File: doc/BRIEF.md
# Delegated Performance Counter Access Unit

This unit sits beside a hart's control-register file and owns a small bank of performance counters. Three counters count fixed events: every clock cycle, the real-time tick, and retired instructions. A parameterised group of programmable counters each count pulses on their own event line and each has an event-selector register. The unit does not generate events. It only counts the pulses it is given. Each counter stops while its bit in a supervisor-visible inhibit register is set.

Access rights come from a machine-level enable mask, a supervisor-level enable mask and a single machine-level delegation bit. Normally only machine mode may write counters and selectors. When delegation is on, supervisor code can reach the counters that the machine mask enables. It does this indirectly: it writes a counter number to an index register, then reads or writes one of two alias registers. One alias maps to the indexed counter and the other to its event selector.

CSR accesses arrive as plain single-cycle strobes with no back-pressure. The response (read data and an illegal-access flag) appears on the registered outputs in the cycle after the strobe. Both outputs are zero in every other cycle.

Top module: `pcg_top`

## Requirements
- R1: After reset, all counters, event selectors, both enable masks, the delegation bit, the inhibit register and the index register read as zero.
- R2: Counter 0 counts clocks, counter 1 counts `time_tick`, counter 2 counts `instret_pulse`, and counter 3+j counts `event_hit[j]`. A counter whose inhibit bit is set holds its value.
- R3: If a write to a counter and an increment of that counter fall in the same cycle, the written value is stored and the increment is lost.
- R4: Read-only view 0xC00+i returns counter i. Privilege encoding is 3 = machine, 1 = supervisor, and 0 or 2 = user. Machine mode may always read it. Supervisor mode needs machine-enable bit i. User mode needs machine-enable bit i and supervisor-enable bit i. A denied read, and any write to the view, is illegal.
- R5: Counters at 0xB00+i, selectors at 0x330+j, the machine-enable mask at 0x306 and the delegation bit at 0x30C (bit 0) are accessible from machine mode only. Any other access to them is illegal and changes nothing.
- R6: The supervisor-enable mask (0x106), the inhibit register (0x120) and the index register (0x150) are accessible from machine and supervisor mode. Any access to them from user mode is illegal.
- R7: With the delegation bit clear, supervisor accesses to the counter alias (0x151) or the selector alias (0x152) are illegal. User accesses to them are always illegal. Machine accesses to them are always allowed.
- R8: With delegation on, the counter alias reads and writes the counter named by the index. A supervisor access is illegal if that counter's machine-enable bit is clear.
- R9: The selector alias reaches selector j when the index is 3+j. For indices 0..2 it reads zero and ignores writes.
- R10: An index at or above the counter count makes both aliases read zero and ignore writes, without raising illegal access.
- R11: An alias access in the cycle right after an index write uses the new index.
- R12: A supervisor write to the inhibit register changes only bits whose counter is delegated (delegation bit set and machine-enable bit set). A machine write changes every bit.
- R13: The read data and illegal flag are registered one cycle after the strobe. Both are zero when no access was made. Unmapped addresses are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_priv | input | 2 | Current privilege (3 M, 1 S, else U) |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | CNT_W | Write data |
| time_tick | input | 1 | Increment for the time counter |
| instret_pulse | input | 1 | Increment for the retired-instruction counter |
| event_hit | input | NUM_PROG | Increment per programmable counter |
| csr_rdata | output | CNT_W | Registered read data |
| csr_illegal | output | 1 | Registered illegal-access flag |

## Verification
The hardest state to reach is a supervisor alias access whose outcome depends on four pieces of state at once: the delegation bit, the machine-enable bit of the indexed counter, whether the index is in range, and the index value written in the immediately preceding cycle. Directed sequences build each combination and issue the alias access right after the index write. A long random phase then mixes privileges, addresses, small index values and event pulses. It compares every response against a bench model that tracks all counters cycle by cycle, including cycles where writes collide with increments or hit inhibited counters.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int N_FIXED = 3;

  localparam logic [11:0] ADDR_UVIEW = 12'hC00;
  localparam logic [11:0] ADDR_MCNT  = 12'hB00;
  localparam logic [11:0] ADDR_MEVT  = 12'h330;
  localparam logic [11:0] ADDR_MEN   = 12'h306;
  localparam logic [11:0] ADDR_DELEG = 12'h30C;
  localparam logic [11:0] ADDR_SEN   = 12'h106;
  localparam logic [11:0] ADDR_SINH  = 12'h120;
  localparam logic [11:0] ADDR_SIDX  = 12'h150;
  localparam logic [11:0] ADDR_ACNT  = 12'h151;
  localparam logic [11:0] ADDR_AEVT  = 12'h152;

  typedef enum logic [3:0] {
    K_NONE, K_UVIEW, K_MCNT, K_MEVT, K_MEN, K_DELEG,
    K_SEN, K_SINH, K_SIDX, K_ACNT, K_AEVT
  } acc_kind_e;
endpackage

// File: rtl/pcg_decode.sv
module pcg_decode
  import pcg_pkg::*;
#(
  parameter int NCNT  = 7,
  parameter int NP    = 4,
  parameter int IDX_W = 4
) (
  input  logic [11:0]      addr,
  input  logic [1:0]       priv,
  input  logic             is_wr,
  input  logic [NCNT-1:0]  men,
  input  logic [NCNT-1:0]  sen,
  input  logic             deleg,
  input  logic [IDX_W-1:0] idx,
  output acc_kind_e        kind,
  output logic [IDX_W-1:0] num,
  output logic             in_range,
  output logic             illegal
);
  localparam int XW = 1 << IDX_W;

  logic [XW-1:0] men_x, sen_x;
  logic [11:0]   off_u, off_m, off_e;
  logic          lvl_m, lvl_s;

  assign men_x = XW'(men);
  assign sen_x = XW'(sen);
  assign off_u = addr - ADDR_UVIEW;
  assign off_m = addr - ADDR_MCNT;
  assign off_e = addr - ADDR_MEVT;
  assign lvl_m = (priv == PRIV_M);
  assign lvl_s = (priv == PRIV_S);

  always_comb begin
    kind     = K_NONE;
    num      = '0;
    in_range = 1'b1;
    if (off_u < 12'(NCNT)) begin
      kind = K_UVIEW;
      num  = off_u[IDX_W-1:0];
    end else if (off_m < 12'(NCNT)) begin
      kind = K_MCNT;
      num  = off_m[IDX_W-1:0];
    end else if (off_e < 12'(NP)) begin
      kind = K_MEVT;
      num  = off_e[IDX_W-1:0];
    end else begin
      unique case (addr)
        ADDR_MEN:   kind = K_MEN;
        ADDR_DELEG: kind = K_DELEG;
        ADDR_SEN:   kind = K_SEN;
        ADDR_SINH:  kind = K_SINH;
        ADDR_SIDX:  kind = K_SIDX;
        ADDR_ACNT:  kind = K_ACNT;
        ADDR_AEVT:  kind = K_AEVT;
        default:    kind = K_NONE;
      endcase
      if (kind == K_ACNT || kind == K_AEVT) begin
        num      = idx;
        in_range = ({{(32-IDX_W){1'b0}}, idx} < 32'(NCNT));
      end
    end
  end

  always_comb begin
    unique case (kind)
      K_UVIEW: illegal = is_wr || !(lvl_m || (lvl_s && men_x[num]) ||
                                    (!lvl_m && !lvl_s && men_x[num] && sen_x[num]));
      K_MCNT, K_MEVT, K_MEN, K_DELEG: illegal = !lvl_m;
      K_SEN, K_SINH, K_SIDX:          illegal = !(lvl_m || lvl_s);
      K_ACNT, K_AEVT: begin
        if (lvl_m)           illegal = 1'b0;
        else if (!lvl_s)     illegal = 1'b1;
        else if (!deleg)     illegal = 1'b1;
        else if (in_range)   illegal = !men_x[num];
        else                 illegal = 1'b0;
      end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/pcg_counter.sv
module pcg_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         inhibit,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)              q <= '0;
    else if (wr_en)          q <= wdata;
    else if (inc && !inhibit) q <= q + W'(1);
  end

  // R3: a software write beats a same-cycle increment
  a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wdata));
  // R2: inhibited counter does not move unless written
  a_r2_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && inhibit) |=> $stable(q));
endmodule

// File: rtl/pcg_top.sv
module pcg_top
  import pcg_pkg::*;
#(
  parameter int NUM_PROG = 4,
  parameter int CNT_W    = 32,
  parameter int EVT_W    = 8,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [11:0]         csr_addr,
  input  logic [1:0]          csr_priv,
  input  logic                csr_rd,
  input  logic                csr_wr,
  input  logic [CNT_W-1:0]    csr_wdata,
  input  logic                time_tick,
  input  logic                instret_pulse,
  input  logic [NUM_PROG-1:0] event_hit,
  output logic [CNT_W-1:0]    csr_rdata,
  output logic                csr_illegal
);
  localparam int NCNT = N_FIXED + NUM_PROG;

  logic [NCNT-1:0]  men_q, sen_q, sinh_q;
  logic             deleg_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q [NCNT];
  logic [EVT_W-1:0] evt_q [NUM_PROG];

  acc_kind_e        kind;
  logic [IDX_W-1:0] num;
  logic             in_range, illegal;
  logic             go_wr;
  logic [NCNT-1:0]  inc_vec, cnt_we, sinh_mask;
  logic [NUM_PROG-1:0] evt_we;

  pcg_decode #(.NCNT(NCNT), .NP(NUM_PROG), .IDX_W(IDX_W)) u_decode (
    .addr(csr_addr), .priv(csr_priv), .is_wr(csr_wr),
    .men(men_q), .sen(sen_q), .deleg(deleg_q), .idx(idx_q),
    .kind(kind), .num(num), .in_range(in_range), .illegal(illegal)
  );

  assign go_wr   = csr_wr && !illegal;
  assign inc_vec = {event_hit, instret_pulse, time_tick, 1'b1};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign cnt_we[i] = go_wr && (kind == K_MCNT || kind == K_ACNT) &&
                       (num == IDX_W'(i));
    pcg_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_vec[i]), .inhibit(sinh_q[i]),
      .wr_en(cnt_we[i]), .wdata(csr_wdata), .q(cnt_q[i])
    );
  end

  for (genvar j = 0; j < NUM_PROG; j++) begin : g_evt
    assign evt_we[j] = go_wr &&
      ((kind == K_MEVT && num == IDX_W'(j)) ||
       (kind == K_AEVT && num == IDX_W'(j + N_FIXED)));
    always_ff @(posedge clk) begin
      if (!rst_n)         evt_q[j] <= '0;
      else if (evt_we[j]) evt_q[j] <= csr_wdata[EVT_W-1:0];
    end
  end

  // supervisor may only touch inhibit bits of delegated counters
  assign sinh_mask = (csr_priv == PRIV_M) ? '1 : (deleg_q ? men_q : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      men_q   <= '0;
      sen_q   <= '0;
      sinh_q  <= '0;
      deleg_q <= 1'b0;
      idx_q   <= '0;
    end else if (go_wr) begin
      unique case (kind)
        K_MEN:   men_q   <= csr_wdata[NCNT-1:0];
        K_SEN:   sen_q   <= csr_wdata[NCNT-1:0];
        K_DELEG: deleg_q <= csr_wdata[0];
        K_SIDX:  idx_q   <= csr_wdata[IDX_W-1:0];
        K_SINH:  sinh_q  <= (sinh_q & ~sinh_mask) | (csr_wdata[NCNT-1:0] & sinh_mask);
        default: ;
      endcase
    end
  end

  logic [CNT_W-1:0] cnt_sel, rd_mux;
  logic [EVT_W-1:0] evt_sel;
  logic [IDX_W-1:0] evt_num;
  logic             evt_ok;

  assign evt_ok  = (kind == K_MEVT) || (num >= IDX_W'(N_FIXED));
  assign evt_num = (kind == K_AEVT) ? num - IDX_W'(N_FIXED) : num;

  always_comb begin
    cnt_sel = '0;
    for (int i = 0; i < NCNT; i++)
      if (num == IDX_W'(i)) cnt_sel = cnt_q[i];
    evt_sel = '0;
    for (int j = 0; j < NUM_PROG; j++)
      if (evt_ok && evt_num == IDX_W'(j)) evt_sel = evt_q[j];
  end

  always_comb begin
    unique case (kind)
      K_UVIEW, K_MCNT: rd_mux = cnt_sel;
      K_ACNT:          rd_mux = in_range ? cnt_sel : '0;
      K_MEVT, K_AEVT:  rd_mux = in_range ? CNT_W'(evt_sel) : '0;
      K_MEN:           rd_mux = CNT_W'(men_q);
      K_SEN:           rd_mux = CNT_W'(sen_q);
      K_SINH:          rd_mux = CNT_W'(sinh_q);
      K_DELEG:         rd_mux = CNT_W'(deleg_q);
      K_SIDX:          rd_mux = CNT_W'(idx_q);
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_rdata   <= '0;
      csr_illegal <= 1'b0;
    end else begin
      csr_rdata   <= (csr_rd && !illegal) ? rd_mux : '0;
      csr_illegal <= (csr_rd || csr_wr) && illegal;
    end
  end

  // R13: quiet response when nothing was accessed
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_rd || csr_wr) |=> (!csr_illegal && csr_rdata == '0));
  // R5: machine enable mask cannot be changed below machine mode
  a_r5_men_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_priv != PRIV_M && csr_addr == ADDR_MEN) |=> $stable(men_q));
  // R7: alias window closed for supervisor when delegation is off
  a_r7_alias_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_rd || csr_wr) && csr_priv == PRIV_S && !deleg_q &&
     (csr_addr == ADDR_ACNT || csr_addr == ADDR_AEVT)) |=> csr_illegal);
  // R4: user read of the cycle view needs both enable bits
  a_r4_user_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_priv == PRIV_U && csr_addr == ADDR_UVIEW &&
     !(men_q[0] && sen_q[0])) |=> (csr_illegal && csr_rdata == '0));
endmodule

// File: tb/pcg_top_bench.sv
`timescale 1ns/1ps
module pcg_top_bench;
  localparam int NP   = 4;
  localparam int NC   = 7;
  localparam int CW   = 32;

  localparam logic [11:0] A_UV = 12'hC00, A_MC = 12'hB00, A_ME = 12'h330;
  localparam logic [11:0] A_MEN = 12'h306, A_DL = 12'h30C, A_SEN = 12'h106;
  localparam logic [11:0] A_SI = 12'h120, A_IX = 12'h150, A_AC = 12'h151, A_AE = 12'h152;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_priv = '0;
  logic        csr_rd = 1'b0, csr_wr = 1'b0;
  logic [CW-1:0] csr_wdata = '0;
  logic        time_tick = 1'b0, instret_pulse = 1'b0;
  logic [NP-1:0] event_hit = '0;
  logic [CW-1:0] csr_rdata;
  logic        csr_illegal;

  always #4 clk = ~clk;

  pcg_top u_pcg_top (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_priv(csr_priv),
    .csr_rd(csr_rd), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .time_tick(time_tick), .instret_pulse(instret_pulse), .event_hit(event_hit),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model
  logic [CW-1:0] m_cnt [16];
  logic [7:0]    m_evt [16];
  logic [15:0]   m_men = '0, m_sen = '0, m_inh = '0;
  logic          m_dl = 1'b0;
  int            m_ix = 0;

  function automatic int kind_of(input logic [11:0] a, output int n);
    n = 0;
    if (a >= A_UV && a < A_UV + NC) begin n = int'(a - A_UV); return 1; end
    if (a >= A_MC && a < A_MC + NC) begin n = int'(a - A_MC); return 2; end
    if (a >= A_ME && a < A_ME + NP) begin n = int'(a - A_ME); return 3; end
    if (a == A_MEN) return 4;
    if (a == A_DL)  return 5;
    if (a == A_SEN) return 6;
    if (a == A_SI)  return 7;
    if (a == A_IX)  return 8;
    if (a == A_AC) begin n = m_ix; return 9; end
    if (a == A_AE) begin n = m_ix; return 10; end
    return 0;
  endfunction

  task automatic access(input logic [11:0] a, input logic [1:0] p, input bit rd,
                        input bit wr, input logic [CW-1:0] wd, input string tag);
    int k, n;
    bit ism, iss, ill;
    logic [CW-1:0] er;
    logic [CW-1:0] nc [16];
    logic [NP+2:0] incs;
    k   = kind_of(a, n);
    ism = (p == PM);
    iss = (p == PS);
    case (k)
      0: ill = 1;
      1: ill = wr || !(ism || (iss && m_men[n]) || (!ism && !iss && m_men[n] && m_sen[n]));
      2, 3, 4, 5: ill = !ism;
      6, 7, 8: ill = !(ism || iss);
      default: ill = ism ? 0 : (!iss ? 1 : (!m_dl ? 1 : (n < NC ? !m_men[n] : 0)));
    endcase
    er = '0;
    if (rd && !ill) begin
      case (k)
        1, 2: er = m_cnt[n];
        3:    er = CW'(m_evt[n]);
        4:    er = CW'(m_men);
        5:    er = CW'(m_dl);
        6:    er = CW'(m_sen);
        7:    er = CW'(m_inh);
        8:    er = CW'(m_ix);
        9:    er = (n < NC) ? m_cnt[n] : '0;
        10:   er = (n >= 3 && n < NC) ? CW'(m_evt[n-3]) : '0;
        default: er = '0;
      endcase
    end
    // next state
    incs = {event_hit, instret_pulse, time_tick, 1'b1};
    for (int i = 0; i < NC; i++)
      nc[i] = (incs[i] && !m_inh[i]) ? m_cnt[i] + 1 : m_cnt[i];
    csr_addr = a; csr_priv = p; csr_rd = rd; csr_wr = wr; csr_wdata = wd;
    if (wr && !ill) begin
      case (k)
        2: nc[n] = wd;
        9: if (n < NC) nc[n] = wd;
        3: m_evt[n] = wd[7:0];
        10: if (n >= 3 && n < NC) m_evt[n-3] = wd[7:0];
        4: m_men = {9'd0, wd[NC-1:0]};
        5: m_dl = wd[0];
        6: m_sen = {9'd0, wd[NC-1:0]};
        8: m_ix = int'(wd[3:0]);
        7: for (int i = 0; i < NC; i++)
             if (ism || (m_dl && m_men[i])) m_inh[i] = wd[i];
        default: ;
      endcase
    end
    for (int i = 0; i < NC; i++) m_cnt[i] = nc[i];
    @(posedge clk);
    @(negedge clk);
    csr_rd = 1'b0; csr_wr = 1'b0;
    checks++;
    if (csr_rdata !== er || csr_illegal !== ((rd || wr) && ill)) begin
      errors++;
      $display("FAIL %s addr=%h priv=%0d rd=%0d wr=%0d: rdata=%h ill=%b expected rdata=%h ill=%b",
               tag, a, p, rd, wr, csr_rdata, csr_illegal, er, (rd || wr) && ill);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) access(12'h000, PM, 0, 0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_cnt[i] = '0; m_evt[i] = '0; end
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    access(A_MC + 3, PM, 1, 0, '0, "R1");
    access(A_MEN, PM, 1, 0, '0, "R1");
    access(A_SI, PM, 1, 0, '0, "R1");
    access(A_IX, PM, 1, 0, '0, "R1");
    access(A_ME + 1, PM, 1, 0, '0, "R1");
    // R2 counting and inhibit
    time_tick = 1; event_hit = 4'b0101;
    idle(3, "R13");
    time_tick = 0; event_hit = '0;
    access(A_MC + 1, PM, 1, 0, '0, "R2");
    access(A_MC + 5, PM, 1, 0, '0, "R2");
    access(A_MC + 0, PM, 1, 0, '0, "R2");
    access(A_SI, PM, 0, 1, 32'h0000_0011, "R2");
    instret_pulse = 1; event_hit = 4'b1111;
    idle(2, "R2");
    instret_pulse = 0; event_hit = '0;
    access(A_MC + 0, PM, 1, 0, '0, "R2");
    access(A_MC + 4, PM, 1, 0, '0, "R2");
    access(A_MC + 2, PM, 1, 0, '0, "R2");
    access(A_SI, PM, 0, 1, '0, "R2");
    // R3 write beats increment
    instret_pulse = 1;
    access(A_MC + 2, PM, 0, 1, 32'hFFFF_FFF0, "R3");
    instret_pulse = 0;
    access(A_MC + 2, PM, 1, 0, '0, "R3");
    access(A_MC + 0, PM, 0, 1, 32'd100, "R3");
    access(A_MC + 0, PM, 1, 0, '0, "R3");
    // R4 read view permissions
    access(A_UV + 3, PU, 1, 0, '0, "R4");
    access(A_UV + 3, PS, 1, 0, '0, "R4");
    access(A_MEN, PM, 0, 1, 32'h0000_0009, "R4");
    access(A_UV + 3, PS, 1, 0, '0, "R4");
    access(A_UV + 3, PU, 1, 0, '0, "R4");
    access(A_SEN, PS, 0, 1, 32'h0000_000A, "R4");
    access(A_UV + 3, PU, 1, 0, '0, "R4");
    access(A_UV + 1, PU, 1, 0, '0, "R4");
    access(A_UV + 0, PM, 0, 1, 32'd5, "R4");
    // R5 machine-only
    access(A_MEN, PS, 0, 1, 32'h7F, "R5");
    access(A_MEN, PM, 1, 0, '0, "R5");
    access(A_MC + 3, PS, 0, 1, 32'd7, "R5");
    access(A_ME + 0, PS, 1, 0, '0, "R5");
    access(A_DL, PU, 0, 1, 32'd1, "R5");
    // R6 supervisor registers
    access(A_SEN, PU, 0, 1, 32'h7F, "R6");
    access(A_IX, PU, 1, 0, '0, "R6");
    access(A_IX, PS, 0, 1, 32'd3, "R6");
    access(A_IX, PS, 1, 0, '0, "R6");
    // R7 alias closed
    access(A_AC, PS, 1, 0, '0, "R7");
    access(A_AE, PS, 0, 1, 32'd9, "R7");
    access(A_AC, PU, 1, 0, '0, "R7");
    access(A_AC, PM, 1, 0, '0, "R7");
    // R8 / R11 delegated path
    access(A_DL, PM, 0, 1, 32'd1, "R8");
    access(A_IX, PS, 0, 1, 32'd3, "R11");
    access(A_AC, PS, 0, 1, 32'h1234_5678, "R11");
    access(A_MC + 3, PM, 1, 0, '0, "R8");
    access(A_IX, PS, 0, 1, 32'd4, "R11");
    access(A_AC, PS, 1, 0, '0, "R8");
    // R9 selector alias
    access(A_IX, PS, 0, 1, 32'd6, "R9");
    access(A_AE, PS, 0, 1, 32'h0000_00A5, "R9");
    access(A_ME + 3, PM, 1, 0, '0, "R9");
    access(A_IX, PS, 0, 1, 32'd0, "R9");
    access(A_AE, PS, 0, 1, 32'd77, "R9");
    access(A_AE, PS, 1, 0, '0, "R9");
    // R10 out of range index
    access(A_IX, PS, 0, 1, 32'd12, "R10");
    access(A_AC, PS, 0, 1, 32'd55, "R10");
    access(A_AC, PS, 1, 0, '0, "R10");
    access(A_AE, PS, 1, 0, '0, "R10");
    // R12 inhibit masking
    access(A_SI, PS, 0, 1, 32'h7F, "R12");
    access(A_SI, PS, 1, 0, '0, "R12");
    access(A_SI, PM, 0, 1, 32'h7F, "R12");
    access(A_SI, PS, 0, 1, 32'h00, "R12");
    access(A_SI, PM, 1, 0, '0, "R12");
    // R13 unmapped
    access(12'h7C0, PM, 1, 0, '0, "R13");
    idle(1, "R13");
    // random phase
    for (int it = 0; it < 3000; it++) begin
      int sel;
      logic [11:0] a;
      logic [1:0] p;
      logic [CW-1:0] wd;
      bit w;
      sel = $urandom_range(0, 10);
      case (sel)
        0: a = A_UV + 12'($urandom_range(0, NC-1));
        1: a = A_MC + 12'($urandom_range(0, NC-1));
        2: a = A_ME + 12'($urandom_range(0, NP-1));
        3: a = A_MEN;
        4: a = A_DL;
        5: a = A_SEN;
        6: a = A_SI;
        7: a = A_IX;
        8: a = A_AC;
        9: a = A_AE;
        default: a = 12'h7C0;
      endcase
      case ($urandom_range(0, 6))
        0, 1: p = PM;
        2, 3, 4: p = PS;
        5: p = PU;
        default: p = 2'd2;
      endcase
      wd = $urandom;
      if (a == A_IX) wd = CW'($urandom_range(0, 9));
      if (a == A_DL) wd = CW'($urandom_range(0, 3) != 0);
      w = $urandom_range(0, 1);
      time_tick = $urandom_range(0, 1);
      instret_pulse = $urandom_range(0, 1);
      event_hit = NP'($urandom);
      access(a, p, !w, w, wd, "R8");
    end
    time_tick = 0; instret_pulse = 0; event_hit = '0;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule